// File: doc/BRIEF.md
# Event Timebase Counter

This block keeps the global time of an event receiver in the event clock domain. It has a timestamp counter and a seconds register. The counter advances on ticks from one of three selectable sources. The first is a strobe raised when a timestamp-clock event code is decoded. The second is a free-running tick from a programmable divider of the event clock. The third is a rising edge on a chosen distributed bus bit. A decoded timestamp-reset event does not clear the counter at once. It arms a pending clear, and that clear takes effect on the next active tick.

The seconds value arrives one bit per event. One decoded code shifts in a '0' and another shifts in a '1', most significant bit first. The shifted value is moved into the seconds register only on the tick that clears the counter, so both halves of the time change together. A latch strobe takes a snapshot of both counters. A record strobe builds an 80-bit word for an event FIFO. That word holds the event code and the time at which the code was received.

The action strobes come from an upstream mapping decoder, one cycle wide and already qualified. Any of them may arrive on any cycle.

Top module: `ts_timebase`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe or tick, `ts_count`, `sec_count`, `latch_ts`, `latch_sec`, `rec_data` and `rec_valid` are all zero.
- R2: With `src_sel` = 0, `ts_count` goes up by one on the clock edge after each cycle in which `act_ts_tick` is high, and holds on other cycles.
- R3: With `src_sel` = 1, a divider ticks once every `div_val` event clock cycles. A `div_val` of 0 or 1 ticks on every cycle. The divider runs whatever source is selected.
- R4: With `src_sel` = 2, the counter advances once for each low-to-high change of bit `dbus_sel` of `dbus`, compared with its value on the previous cycle. A bit held high counts only once.
- R5: With `src_sel` = 3, no tick occurs, and `ts_count` holds even while `act_ts_tick` pulses.
- R6: `act_ts_reset` arms a pending clear and leaves `ts_count` unchanged. The next tick after the arming cycle sets `ts_count` to 0, not to 1. A tick in the same cycle as `act_ts_reset` counts normally.
- R7: `act_sec0` shifts a 0 into the low end of a 32-bit seconds shift register, and `act_sec1` shifts a 1. The earlier bits move toward the MSB. When both strobes are high, a 1 is shifted.
- R8: On the tick that clears the counter, `sec_count` takes the shift register contents as they stood before that cycle's shift. `sec_count` changes on no other cycle.
- R9: `act_latch` copies the values of `ts_count` and `sec_count` from before that clock edge into `latch_ts` and `latch_sec`. Both hold when it is low.
- R10: On the edge after `act_record` is high, `rec_valid` is high for one cycle. `rec_data` then holds zeros in [79:72], `evt_code` in [71:64], the prior `sec_count` in [63:32] and the prior `ts_count` in [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Tick source: 0 event strobe, 1 divider, 2 bus edge, 3 none |
| div_val | input | 32 | Divider ratio for source 1 |
| dbus | input | 8 | Distributed bus bits |
| dbus_sel | input | 3 | Bus bit used as the tick source |
| evt_code | input | 8 | Code of the event decoded this cycle |
| act_ts_tick | input | 1 | Timestamp-clock event strobe |
| act_ts_reset | input | 1 | Timestamp-reset event strobe |
| act_sec0 | input | 1 | Seconds bit '0' strobe |
| act_sec1 | input | 1 | Seconds bit '1' strobe |
| act_latch | input | 1 | Snapshot request |
| act_record | input | 1 | FIFO record request |
| ts_count | output | 32 | Live timestamp counter |
| sec_count | output | 32 | Live seconds register |
| latch_ts | output | 32 | Latched timestamp |
| latch_sec | output | 32 | Latched seconds |
| rec_valid | output | 1 | Record word valid |
| rec_data | output | 80 | Record word: code, seconds, timestamp |

## Verification
The counter is driven from each source in turn. Strobe bursts with gaps separate per-strobe counting from level counting. Divider ratios of 0, 1 and 4 expose off-by-one errors in the period. A bus bit held high for several cycles, while the other bits toggle, shows edge detection and correct bit selection. A full 32-bit seconds pattern with a double strobe, followed by a clear with no tick, a clear with a tick, and a shift on the commit cycle, separates a deferred clear from an immediate one. It also shows whether the seconds commit takes the pre-shift value. A long pseudo-random mix of all strobes and sources is then compared on every clock against the behavioural model.

// File: rtl/ts_timebase.sv
module ts_timebase #(
  parameter int TS_W   = 32,
  parameter int SEC_W  = 32,
  parameter int DIV_W  = 32,
  parameter int DBUS_W = 8,
  parameter int CODE_W = 8,
  parameter int REC_W  = 80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                src_sel,
  input  logic [DIV_W-1:0]          div_val,
  input  logic [DBUS_W-1:0]         dbus,
  input  logic [$clog2(DBUS_W)-1:0] dbus_sel,
  input  logic [CODE_W-1:0]         evt_code,
  input  logic                      act_ts_tick,
  input  logic                      act_ts_reset,
  input  logic                      act_sec0,
  input  logic                      act_sec1,
  input  logic                      act_latch,
  input  logic                      act_record,
  output logic [TS_W-1:0]           ts_count,
  output logic [SEC_W-1:0]          sec_count,
  output logic [TS_W-1:0]           latch_ts,
  output logic [SEC_W-1:0]          latch_sec,
  output logic                      rec_valid,
  output logic [REC_W-1:0]          rec_data
);
  localparam int PAD_W = REC_W - CODE_W - SEC_W - TS_W;

  logic [DIV_W-1:0] div_cnt;
  logic [SEC_W-1:0] sec_shift;
  logic             rst_pend, db_prev, tick;

  wire div_tick = (div_val <= DIV_W'(1)) || (div_cnt >= div_val - DIV_W'(1));
  wire db_cur   = dbus[dbus_sel];
  wire db_edge  = db_cur & ~db_prev;

  always_comb begin
    case (src_sel)
      2'd0:    tick = act_ts_tick;
      2'd1:    tick = div_tick;
      2'd2:    tick = db_edge;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      db_prev <= 1'b0;
    end else begin
      div_cnt <= div_tick ? '0 : div_cnt + DIV_W'(1);
      db_prev <= db_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_count  <= '0;
      sec_count <= '0;
      rst_pend  <= 1'b0;
    end else begin
      if (tick) begin
        if (rst_pend) begin
          ts_count  <= '0;
          sec_count <= sec_shift;
        end else begin
          ts_count <= ts_count + TS_W'(1);
        end
      end
      rst_pend <= (rst_pend & ~tick) | act_ts_reset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sec_shift <= '0;
    else if (act_sec1) sec_shift <= {sec_shift[SEC_W-2:0], 1'b1};
    else if (act_sec0) sec_shift <= {sec_shift[SEC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_ts  <= '0;
      latch_sec <= '0;
      rec_valid <= 1'b0;
      rec_data  <= '0;
    end else begin
      if (act_latch) begin
        latch_ts  <= ts_count;
        latch_sec <= sec_count;
      end
      rec_valid <= act_record;
      if (act_record) rec_data <= {{PAD_W{1'b0}}, evt_code, sec_count, ts_count};
    end
  end

  // R6
  ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_pend) |=> ts_count == '0);
  // R2
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts_count));
  // R8
  sec_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_pend) |=> sec_count == $past(sec_shift));
  // R8
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && rst_pend) |=> $stable(sec_count));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_latch |=> $stable(latch_ts) && $stable(latch_sec));
  // R10
  rec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_record |=> rec_valid && rec_data[TS_W+SEC_W +: CODE_W] == $past(evt_code));
  // R5
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |=> $stable(ts_count));
endmodule

// File: tb/sim_ts_timebase.sv
module sim_ts_timebase;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [31:0] div_val = 32'd0;
  logic [7:0] dbus = 8'd0, evt_code = 8'd0;
  logic [2:0] dbus_sel = 3'd0;
  logic act_ts_tick = 0, act_ts_reset = 0, act_sec0 = 0, act_sec1 = 0, act_latch = 0, act_record = 0;
  logic [31:0] ts_count, sec_count, latch_ts, latch_sec;
  logic rec_valid;
  logic [79:0] rec_data;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  logic [31:0] m_ts, m_sec, m_sh, m_lts, m_lsec, m_div;
  logic m_pend, m_prev, m_rv;
  logic [79:0] m_rec;

  always #2 clk = ~clk;

  ts_timebase u0 (.clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_val(div_val), .dbus(dbus),
    .dbus_sel(dbus_sel), .evt_code(evt_code), .act_ts_tick(act_ts_tick), .act_ts_reset(act_ts_reset),
    .act_sec0(act_sec0), .act_sec1(act_sec1), .act_latch(act_latch), .act_record(act_record),
    .ts_count(ts_count), .sec_count(sec_count), .latch_ts(latch_ts), .latch_sec(latch_sec),
    .rec_valid(rec_valid), .rec_data(rec_data));

  always @(posedge clk) begin
    logic t, dt, bit_now;
    logic [31:0] o_ts, o_sec, o_sh;
    if (!rst_n) begin
      m_ts = 0; m_sec = 0; m_sh = 0; m_lts = 0; m_lsec = 0; m_div = 0;
      m_pend = 0; m_prev = 0; m_rv = 0; m_rec = 0;
    end else begin
      if (div_val == 0 || div_val == 1 || m_div + 1 >= div_val) begin dt = 1; m_div = 0; end
      else begin dt = 0; m_div = m_div + 1; end
      bit_now = dbus[dbus_sel];
      t = (src_sel == 0) ? act_ts_tick : (src_sel == 1) ? dt :
          (src_sel == 2) ? (bit_now && !m_prev) : 1'b0;
      m_prev = bit_now;
      o_ts = m_ts; o_sec = m_sec; o_sh = m_sh;
      if (act_latch) begin m_lts = o_ts; m_lsec = o_sec; end
      m_rv = act_record;
      if (act_record) m_rec = {8'h00, evt_code, o_sec, o_ts};
      if (t) begin
        if (m_pend) begin m_ts = 0; m_sec = o_sh; end
        else m_ts = m_ts + 1;
      end
      m_pend = (m_pend && !t) || act_ts_reset;
      if (act_sec1) m_sh = {m_sh[30:0], 1'b1};
      else if (act_sec0) m_sh = {m_sh[30:0], 1'b0};
    end
  end

  task automatic chk(string what, logic [79:0] act, logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("ts_count", 80'(ts_count), 80'(m_ts));
    chk("sec_count", 80'(sec_count), 80'(m_sec));
    chk("latch", 80'({latch_sec, latch_ts}), 80'({m_lsec, m_lts}));
    chk("rec_valid", 80'(rec_valid), 80'(m_rv));
    if (m_rv) chk("rec_data", rec_data, m_rec);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    act_ts_tick = 0; act_ts_reset = 0; act_sec0 = 0; act_sec1 = 0; act_latch = 0; act_record = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog run did not end");
    finish_run();
  end

  initial begin
    logic [31:0] pat;
    pat = 32'hA5C3_1E69;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("reset ts/sec", 80'({ts_count, sec_count}), 80'd0);
    chk("reset latch", 80'({latch_ts, latch_sec}), 80'd0);
    chk("reset rec", {79'd0, rec_valid} | rec_data, 80'd0);
    rst_n = 1;
    cyc(); cyc();
    tag = "R2";
    src_sel = 0;
    for (int i = 0; i < 24; i++) begin act_ts_tick = (i % 3 != 1); cyc(); end
    tag = "R9";
    act_latch = 1; cyc(); cyc();
    act_ts_tick = 1; act_latch = 1; cyc();
    tag = "R7";
    for (int i = 31; i >= 0; i--) begin
      if (pat[i]) act_sec1 = 1; else act_sec0 = 1;
      if (i == 7) begin act_sec0 = 1; act_sec1 = 1; end
      cyc();
      if (i % 5 == 0) cyc();
    end
    tag = "R6";
    act_ts_reset = 1; cyc();
    for (int i = 0; i < 4; i++) cyc();
    tag = "R8";
    act_ts_tick = 1; act_sec0 = 1; cyc();
    act_ts_tick = 1; cyc();
    act_ts_tick = 1; act_ts_reset = 1; cyc();
    tag = "R6";
    act_ts_tick = 1; act_sec1 = 1; cyc();
    act_ts_tick = 1; cyc();
    tag = "R10";
    for (int i = 0; i < 6; i++) begin
      evt_code = 8'(8'h40 + i * 17); act_record = (i != 2); act_ts_tick = i[0]; cyc();
    end
    cyc();
    tag = "R3";
    src_sel = 1; div_val = 0;
    for (int i = 0; i < 6; i++) cyc();
    div_val = 1;
    for (int i = 0; i < 6; i++) cyc();
    div_val = 4;
    for (int i = 0; i < 22; i++) begin act_latch = (i == 10); cyc(); end
    act_ts_reset = 1; cyc();
    for (int i = 0; i < 6; i++) cyc();
    tag = "R4";
    src_sel = 2; dbus_sel = 5;
    for (int i = 0; i < 30; i++) begin
      dbus = 8'(i * 37);
      dbus[5] = ((i / 4) % 2 == 1) || (i > 24);
      cyc();
    end
    tag = "R5";
    src_sel = 3; div_val = 0;
    for (int i = 0; i < 8; i++) begin act_ts_tick = 1; dbus = 8'(~dbus); cyc(); end
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      src_sel = r[1:0]; div_val = 32'(r[4:2]); dbus = r[12:5]; dbus_sel = r[15:13];
      evt_code = r[23:16]; act_ts_tick = r[24]; act_ts_reset = r[25] & r[26];
      act_sec0 = r[27]; act_sec1 = r[28]; act_latch = r[29]; act_record = r[30];
      cyc();
    end
    finish_run();
  end
endmodule